// File: doc/BRIEF.md
# Mailbox acknowledge interrupt aggregator

This block gathers the acknowledge events of a set of mailbox slots into a single interrupt line for the local processor. Each event input is edge-detected, and a rising edge latches a pending bit in a raw register. A mask register picks the sources that may interrupt. The masked status is the AND of raw and mask, and the interrupt output is high while any masked status bit is set. Software reads the masked status, services the pending sources from the lowest bit upward and clears each one with a write-1-to-clear access.

The mask can be written as a whole. It can also be changed one bit at a time, without a read-modify-write, through a write-1-to-set enable address and a write-1-to-clear disable address. A doorbell register drives one interrupt request per vector toward the peer processor. Writing a one-hot value to it raises the request for that vector.

The register port is a single-cycle write strobe with address and data, and a combinational read of the addressed register.

Top module: `mbox_ack_irq_agg`

## Requirements
- R1: While reset is asserted and right after it is released, the raw, mask and doorbell registers are zero, `irq_out` is 0 and `peer_irq` is 0.
- R2: A 0-to-1 change on `evt_in[i]`, sampled at a clock edge, sets raw bit i at that edge. The bit stays set until it is cleared, even if the input drops. A level that is held high sets the bit only once. The raw register reads at offset 0x400.
- R3: Writing to offset 0x40C clears each raw bit whose data bit is 1 and leaves the other raw bits unchanged. Writing all ones clears every raw bit.
- R4: Writing to offset 0x500 sets each mask bit whose data bit is 1. Mask bits written as 0 are unchanged.
- R5: Writing to offset 0x504 clears each mask bit whose data bit is 1. Mask bits written as 0 are unchanged.
- R6: Writing to offset 0x404 loads the mask register with the data, so writing zero masks every source. The mask reads back at 0x404, and a mask bit of 1 means the source is enabled.
- R7: The masked status at offset 0x408 reads raw AND mask. `irq_out` is 1 exactly when that value is nonzero. When several status bits are pending, clearing them one at a time from the lowest bit upward keeps `irq_out` high until the last one is cleared.
- R8: Writing to offset 0x420 loads the doorbell register, and `peer_irq` equals it from the next cycle on. A one-hot write raises only that vector. The doorbell reads back at 0x420.
- R9: Writes to offsets 0x400 and 0x408 have no effect. Offsets 0x40C, 0x500 and 0x504 read as zero, as does every unmapped offset.
- R10: If a rising event edge and a clear write hit the same raw bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | ADDR_W (12) | Register byte offset for reads and writes |
| wdata | input | NUM_SRC (32) | Write data |
| rdata | output | NUM_SRC (32) | Read data of the register at `addr`, combinational |
| evt_in | input | NUM_SRC (32) | Acknowledge event inputs, one per source |
| peer_irq | output | NUM_SRC (32) | Doorbell interrupt requests toward the peer |
| irq_out | output | 1 | Local interrupt, OR of the masked status |

## Verification
Every register takes effect at the clock edge that samples the write or the event edge. `rdata`, `irq_out` and `peer_irq` show the new value in the cycle right after that edge, with no further delay. The bench drives each stimulus at a falling edge. It then waits through exactly one rising edge and samples at the next falling edge, reading the combinational `rdata` a short delay after `addr` settles. The sweeps walk every bit position through event latching, enable, disable, single-bit clear and the doorbell. After each step the bench compares the results with its own model of raw, mask and doorbell.

// File: rtl/mbox_agg_pkg.sv
package mbox_agg_pkg;
  // Register byte offsets
  localparam int unsigned OFF_RAW  = 'h400;
  localparam int unsigned OFF_MASK = 'h404;
  localparam int unsigned OFF_STAT = 'h408;
  localparam int unsigned OFF_CLR  = 'h40C;
  localparam int unsigned OFF_DB   = 'h420;
  localparam int unsigned OFF_ENA  = 'h500;
  localparam int unsigned OFF_DIS  = 'h504;

  // Set-dominant update: bits in set_v win over bits in clr_v
  function automatic logic [63:0] set_over_clr(input logic [63:0] cur,
                                               input logic [63:0] set_v,
                                               input logic [63:0] clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction
endpackage

// File: rtl/mbox_edge_det.sv
module mbox_edge_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_in,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_in;
  end

  assign rise_o = sig_in & ~sig_q;
endmodule

// File: rtl/mbox_setclr_reg.sv
module mbox_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);
  import mbox_agg_pkg::*;

  logic [63:0] upd_wide;
  logic [W-1:0] d;

  assign upd_wide = set_over_clr(64'(q), 64'(set_v), 64'(clr_v));

  always_comb begin
    if (load_en) d = load_val;
    else         d = upd_wide[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/mbox_ack_irq_agg.sv
module mbox_ack_irq_agg #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic [NUM_SRC-1:0] peer_irq,
  output logic               irq_out
);
  import mbox_agg_pkg::*;

  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_DB   = ADDR_W'(OFF_DB);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(OFF_ENA);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFF_DIS);
  localparam logic [NUM_SRC-1:0] ZERO  = '0;

  // Named internal events, also used by the checker
  logic               clr_hit, ena_hit, dis_hit, mask_hit, db_hit;
  logic [NUM_SRC-1:0] evt_rise;
  logic [NUM_SRC-1:0] raw_q, mask_q, db_q, stat_w;
  logic [NUM_SRC-1:0] clr_bits, ena_bits, dis_bits;

  assign clr_hit  = wr_en && (addr == A_CLR);
  assign ena_hit  = wr_en && (addr == A_ENA);
  assign dis_hit  = wr_en && (addr == A_DIS);
  assign mask_hit = wr_en && (addr == A_MASK);
  assign db_hit   = wr_en && (addr == A_DB);

  assign clr_bits = clr_hit ? wdata : ZERO;
  assign ena_bits = ena_hit ? wdata : ZERO;
  assign dis_bits = dis_hit ? wdata : ZERO;

  mbox_edge_det #(.W(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (evt_in),
    .rise_o (evt_rise)
  );

  mbox_setclr_reg #(.W(NUM_SRC)) u_raw (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (1'b0),
    .load_val (ZERO),
    .set_v    (evt_rise),
    .clr_v    (clr_bits),
    .q        (raw_q)
  );

  mbox_setclr_reg #(.W(NUM_SRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (mask_hit),
    .load_val (wdata),
    .set_v    (ena_bits),
    .clr_v    (dis_bits),
    .q        (mask_q)
  );

  mbox_setclr_reg #(.W(NUM_SRC)) u_db (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (db_hit),
    .load_val (wdata),
    .set_v    (ZERO),
    .clr_v    (ZERO),
    .q        (db_q)
  );

  assign stat_w   = raw_q & mask_q;
  assign irq_out  = |stat_w;
  assign peer_irq = db_q;

  always_comb begin
    unique case (addr)
      A_RAW:   rdata = raw_q;
      A_MASK:  rdata = mask_q;
      A_STAT:  rdata = stat_w;
      A_DB:    rdata = db_q;
      default: rdata = ZERO;
    endcase
  end
endmodule

// File: rtl/mbox_ack_irq_agg_chk.sv
module mbox_ack_irq_agg_chk #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [NUM_SRC-1:0] wdata,
  input logic [NUM_SRC-1:0] peer_irq,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] evt_rise,
  input logic [NUM_SRC-1:0] raw_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               clr_hit,
  input logic               ena_hit,
  input logic               dis_hit,
  input logic               db_hit
);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'('h400);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h408);

  logic ro_wr;
  assign ro_wr = wr_en && ((addr == A_RAW) || (addr == A_STAT));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (raw_q == '0 && mask_q == '0 && peer_irq == '0 && !irq_out));

  // R2
  raw_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_rise) |=> ((raw_q & $past(evt_rise)) == $past(evt_rise)));

  // R2
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hit |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  // R3
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((raw_q & $past(wdata & ~evt_rise)) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && (|(wdata & evt_rise))) |=>
      ((raw_q & $past(wdata & evt_rise)) == $past(wdata & evt_rise)));

  // R4
  mask_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ena_hit |=> (mask_q == ($past(mask_q) | $past(wdata))));

  // R5
  mask_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_hit |=> (mask_q == ($past(mask_q) & ~$past(wdata))));

  // R7
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((raw_q & mask_q) != '0));

  // R7
  irq_no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & mask_q) != '0) |-> irq_out);

  // R8
  doorbell_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_hit |=> (peer_irq == $past(wdata)));

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_wr |=> ($stable(mask_q) && $stable(peer_irq)));
endmodule

bind mbox_ack_irq_agg mbox_ack_irq_agg_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .peer_irq (peer_irq),
  .irq_out  (irq_out),
  .evt_rise (evt_rise),
  .raw_q    (raw_q),
  .mask_q   (mask_q),
  .clr_hit  (clr_hit),
  .ena_hit  (ena_hit),
  .dis_hit  (dis_hit),
  .db_hit   (db_hit)
);

// File: tb/tb_mbox_ack_irq_agg.sv
`timescale 1ns/1ps
module tb_mbox_ack_irq_agg;
  localparam int N  = 32;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic [N-1:0]  evt_in = '0;
  logic [N-1:0]  peer_irq;
  logic          irq_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [N-1:0] raw_m = '0, mask_m = '0, db_m = '0;

  always #4 clk = ~clk;  // 125 MHz

  mbox_ack_irq_agg #(.NUM_SRC(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_in(evt_in), .peer_irq(peer_irq), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] bits);
    @(negedge clk);
    evt_in = bits;
    @(negedge clk);
    evt_in = '0;
    raw_m = raw_m | bits;
  endtask

  task automatic check_all(input string tag);
    logic [N-1:0] v;
    rd(12'h400, v); check({tag, " raw"}, v, raw_m);
    rd(12'h404, v); check({tag, " mask"}, v, mask_m);
    rd(12'h408, v); check({tag, " status"}, v, raw_m & mask_m);
    check({tag, " irq_out"}, N'(irq_out), N'((raw_m & mask_m) != '0));
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    // R1: registers zero in reset
    check_all("R1 in reset");
    check("R1 peer_irq in reset", peer_irq, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");
    rd(12'h420, v); check("R1 doorbell", v, '0);

    // R2: rising edges latch each bit; mask is zero so no interrupt
    for (int i = 0; i < N; i++) begin
      pulse(N'(1) << i);
      rd(12'h400, v); check("R2 raw latch", v, raw_m);
      check("R6 masked irq", N'(irq_out), '0);
    end
    // R3: clear everything, then held level sets only once
    wr(12'h40C, '1); raw_m = '0;
    check_all("R3 clear all");
    @(negedge clk); evt_in = 32'h0000_0011;
    @(negedge clk); raw_m = 32'h0000_0011;
    check_all("R2 level set");
    wr(12'h40C, 32'h0000_0011); raw_m = '0;
    repeat (2) @(negedge clk);
    check_all("R2 held level no re-set");
    evt_in = '0;

    // R4: enable bit by bit
    pulse(32'hF0F0_3C3C);
    for (int i = 0; i < N; i++) begin
      wr(12'h500, N'(1) << i); mask_m = mask_m | (N'(1) << i);
      check_all("R4 enable");
    end
    // R4: zero bits have no effect
    wr(12'h500, '0);
    check_all("R4 zero write");

    // R5: disable pattern and zero bits
    wr(12'h504, 32'hA5A5_0F0F); mask_m = mask_m & ~32'hA5A5_0F0F;
    check_all("R5 disable");
    wr(12'h504, '0);
    check_all("R5 zero write");
    for (int i = 0; i < N; i++) begin
      wr(12'h504, N'(1) << i); mask_m = mask_m & ~(N'(1) << i);
      check_all("R5 disable sweep");
    end

    // R6: direct load and zero masks all
    wr(12'h404, 32'h1234_5678); mask_m = 32'h1234_5678;
    check_all("R6 load");
    wr(12'h404, '0); mask_m = '0;
    check_all("R6 zero");

    // R7: all pending, clear lowest first; irq stays high until last
    pulse('1);
    wr(12'h404, '1); mask_m = '1;
    for (int i = 0; i < N; i++) begin
      check("R7 irq before clear", N'(irq_out), N'(1));
      wr(12'h40C, N'(1) << i); raw_m = raw_m & ~(N'(1) << i);
      check_all("R3 single clear");
    end
    check("R7 irq after last", N'(irq_out), '0);

    // R10: set and clear in the same cycle
    pulse(32'h0000_0009);
    @(negedge clk);
    evt_in = 32'h0000_0008;
    wr_en = 1'b1; addr = 12'h40C; wdata = '1;
    @(negedge clk);
    wr_en = 1'b0; evt_in = '0;
    raw_m = 32'h0000_0008;
    check_all("R10 set wins");

    // R8: doorbell one-hot sweep
    for (int i = 0; i < N; i++) begin
      wr(12'h420, N'(1) << i); db_m = N'(1) << i;
      check("R8 peer_irq", peer_irq, db_m);
      rd(12'h420, v); check("R8 readback", v, db_m);
    end
    wr(12'h420, '0); db_m = '0;
    check("R8 peer_irq cleared", peer_irq, '0);

    // R9: read-only writes ignored, write-only and unmapped read zero
    wr(12'h420, 32'h0000_0100); db_m = 32'h0000_0100;
    wr(12'h400, 32'h5555_AAAA);
    wr(12'h408, 32'hFFFF_0000);
    check_all("R9 ro write");
    check("R9 peer_irq kept", peer_irq, db_m);
    rd(12'h40C, v); check("R9 clear reads 0", v, '0);
    rd(12'h500, v); check("R9 enable reads 0", v, '0);
    rd(12'h504, v); check("R9 disable reads 0", v, '0);
    rd(12'h410, v); check("R9 unmapped reads 0", v, '0);
    rd(12'h000, v); check("R9 offset 0 reads 0", v, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule